// File: doc/BRIEF.md
# I2C Multi-Address Slave Controller

This block is the slave side of an I2C port. It samples the shared SCL and SDA lines, finds START and STOP conditions, and collects the address byte that follows each START. The upper seven bits of that byte are compared in parallel against four programmable identity registers and, if enabled, a general call identity. An addressed slave acknowledges and then moves bytes between the bus and a pair of holding registers: one for receive and one for transmit. A status register reports what happened. A slave that is not addressed stays silent until the next START.

The host reaches the registers through a simple single-cycle strobe interface. Both bus lines are open drain, so each one is modelled as an output enable: when the enable is high the pad pulls the line low, and when it is low the line is released. During a read, if no transmit byte is ready, the slave holds SCL low until the host supplies one. A loopback mode lets software test its own data path without using the bus.

Register map (4-bit offset): 0x0 configuration, 0x1 general call identity, 0x2 to 0x5 identity slots 0 to 3, 0x6 receive data, 0x7 transmit data, 0x8 status. Status bits: [7] STOP seen, [6] transmit empty, [5] receive full, [4] direction, [3] general call hit, [2:1] matched slot, [0] reads 0.

Top module: `i2c_multi_slave`

## Requirements
- R1: After reset, status reads 0x40 (only bit 6, transmit empty, is set). Configuration, identity slots and receive data all read 0, and neither line is driven.
- R2: An address byte whose bits [7:1] equal bits [7:1] of any identity slot (offsets 0x2 to 0x5) is accepted. Bit 0 of the slot plays no part in the match. The slave pulls SDA low for the whole ninth SCL pulse.
- R3: On an accepted address, status bits [2:1] take the lowest-numbered matching slot, and status bit 4 takes address bit 0, the direction bit.
- R4: For an address that matches nothing, the slave gives no acknowledge, drives neither line, and accepts no data until the next START.
- R5: An address whose bits [7:1] equal those of the general call register (0x1) is accepted only when configuration bits 1 and 0 are both set. It then sets status bit 3. A match on an identity slot takes precedence.
- R6: While configuration bit 0 is clear, the slave ignores START, drives neither line, and does not flag STOP.
- R7: In a write, each data byte is shifted in MSB first on the SCL rising edges and acknowledged. The byte is then stored in receive data (0x6) and status bit 5 is set. Reading 0x6 clears bit 5.
- R8: Writing transmit data (0x7) clears status bit 6. In a read, the byte is loaded when it is due and bit 6 is set again. The byte is sent MSB first, and SDA changes only after SCL falls. After a NACK from the master, the slave leaves the bus alone until the next START.
- R9: If status bit 6 is set when a read byte is due, the slave holds SCL low until 0x7 is written. Once it is written, SDA is set up at least one cycle before SCL is released.
- R10: A STOP seen while enabled sets status bit 7. Reading status (0x8) clears it.
- R11: Writes to identity slots between a START and the following STOP are dropped. Writes made outside that window take effect.
- R12: With configuration bit 2 set, a write to 0x7 is placed in receive data and sets status bit 5. Status bit 6 does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read side effects) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The bench builds the block with its defaults: four identity slots and a two-flop line synchronizer. With four slots, two of them can be loaded with the same upper bits, which makes the lowest-index priority observable. One slot has bit 0 set, so the bench can show that bit 0 is ignored in the match. The two-flop synchronizer gives a fixed three-cycle lag from a line edge to the slave's response. The bench's master runs at quarter-bit steps of eight clocks, which keeps every slave reaction inside the SCL low phase where it belongs.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int REG_AW = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_RX, ST_ACKR,
    ST_TXW, ST_TX, ST_MACK, ST_IGN
  } slv_st_e;

  localparam logic [REG_AW-1:0] RA_CFG  = 4'h0;
  localparam logic [REG_AW-1:0] RA_GCID = 4'h1;
  localparam logic [REG_AW-1:0] RA_ID0  = 4'h2;
  localparam logic [REG_AW-1:0] RA_RXD  = 4'h6;
  localparam logic [REG_AW-1:0] RA_TXD  = 4'h7;
  localparam logic [REG_AW-1:0] RA_STAT = 4'h8;

  // seven-bit identity comparison; direction position excluded
  function automatic logic id_match(input logic [7:0] id, input logic [7:0] abyte);
    return id[7:1] == abyte[7:1];
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_evt = scl_s && scl_q && sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int N_ID = 4,
  localparam int IW = (N_ID > 1) ? $clog2(N_ID) : 1
) (
  input  logic [N_ID-1:0][7:0] ids,
  input  logic [7:0]           gc_id,
  input  logic                 gc_en,
  input  logic [7:0]           abyte,
  output logic                 id_hit,
  output logic                 gc_hit,
  output logic [IW-1:0]        id_idx
);
  logic [N_ID-1:0] hits;

  for (genvar g = 0; g < N_ID; g++) begin : g_cmp
    assign hits[g] = id_match(ids[g], abyte);
  end

  always_comb begin
    id_idx = '0;
    for (int i = N_ID - 1; i >= 0; i--) begin
      if (hits[i]) id_idx = IW'(i);
    end
  end

  assign id_hit = |hits;
  assign gc_hit = gc_en && !id_hit && id_match(gc_id, abyte);
endmodule

// File: rtl/i2c_multi_slave.sv
module i2c_multi_slave
  import i2cs_pkg::*;
#(
  parameter int N_ID        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int IW = (N_ID > 1) ? $clog2(N_ID) : 1;

  // bus events
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  // registers
  logic [N_ID-1:0][7:0] id_q;
  logic [7:0] gcid_q, rxd_q, txd_q, sh_q;
  logic en_q, gce_q, lpb_q;
  logic rxf_q, txe_q, stop_q, dir_q, gc_q, busy_q, nack_q, txw_q;
  logic [IW-1:0] idx_q;
  logic [3:0] cnt_q;
  slv_st_e st_q;

  // matcher
  logic id_hit, gc_hit, addr_hit;
  logic [IW-1:0] id_idx;

  i2cs_addr_match #(.N_ID(N_ID)) u_match (
    .ids(id_q), .gc_id(gcid_q), .gc_en(gce_q && en_q), .abyte(sh_q),
    .id_hit(id_hit), .gc_hit(gc_hit), .id_idx(id_idx)
  );
  assign addr_hit = id_hit || gc_hit;

  // named internal events
  logic addr_done, rx_done, load_tx, wr_tx, rd_rx, rd_stat;
  assign addr_done = (st_q == ST_ADDR) && scl_fall && (cnt_q == 4'd8);
  assign rx_done   = (st_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign load_tx   = (st_q == ST_TXW) && !txe_q;
  assign wr_tx     = reg_wr && (reg_addr == RA_TXD);
  assign rd_rx     = reg_rd && (reg_addr == RA_RXD);
  assign rd_stat   = reg_rd && (reg_addr == RA_STAT);

  // bus sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      gc_q   <= 1'b0;
      idx_q  <= '0;
      nack_q <= 1'b0;
      txw_q  <= 1'b0;
    end else begin
      txw_q <= (st_q == ST_TXW);
      if (start_evt) begin
        st_q   <= en_q ? ST_ADDR : ST_IDLE;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (stop_evt) begin
        st_q   <= ST_IDLE;
        busy_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end
            if (addr_done) begin
              if (addr_hit) begin
                st_q  <= ST_ACKA;
                dir_q <= sh_q[0];
                gc_q  <= gc_hit;
                idx_q <= id_idx;
              end else begin
                st_q <= ST_IGN;
              end
            end
            if (rx_done) st_q <= ST_ACKR;
          end
          ST_ACKA: if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= dir_q ? ST_TXW : ST_RX;
          end
          ST_ACKR: if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= ST_RX;
          end
          ST_TXW: if (load_tx) begin
            sh_q <= txd_q;
            st_q <= ST_TX;
          end
          ST_TX: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) st_q <= ST_MACK;
              else sh_q <= {sh_q[6:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) nack_q <= sda_s;
            if (scl_fall) begin
              cnt_q <= '0;
              st_q  <= nack_q ? ST_IGN : ST_TXW;
            end
          end
          ST_IDLE, ST_IGN: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // host-visible registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      gcid_q <= '0;
      en_q   <= 1'b0;
      gce_q  <= 1'b0;
      lpb_q  <= 1'b0;
      rxd_q  <= '0;
      txd_q  <= '0;
      rxf_q  <= 1'b0;
      txe_q  <= 1'b1;
      stop_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_CFG) {lpb_q, gce_q, en_q} <= reg_wdata[2:0];
      if (reg_wr && reg_addr == RA_GCID) gcid_q <= reg_wdata;
      for (int i = 0; i < N_ID; i++) begin
        if (reg_wr && !busy_q && reg_addr == RA_ID0 + REG_AW'(i)) id_q[i] <= reg_wdata;
      end
      if (wr_tx && lpb_q) begin
        rxd_q <= reg_wdata;
        rxf_q <= 1'b1;
      end else if (rx_done) begin
        rxd_q <= sh_q;
        rxf_q <= 1'b1;
      end else if (rd_rx) begin
        rxf_q <= 1'b0;
      end
      if (wr_tx && !lpb_q) begin
        txd_q <= reg_wdata;
        txe_q <= 1'b0;
      end else if (load_tx) begin
        txe_q <= 1'b1;
      end
      if (stop_evt && en_q) stop_q <= 1'b1;
      else if (rd_stat) stop_q <= 1'b0;
    end
  end

  // pad enables
  assign sda_oe = (st_q == ST_ACKA) || (st_q == ST_ACKR) || ((st_q == ST_TX) && !sh_q[7]);
  assign scl_oe = (st_q == ST_TXW) || txw_q;

  // read mux
  logic [7:0] stat_w;
  assign stat_w = {stop_q, txe_q, rxf_q, dir_q, gc_q, 2'(idx_q), 1'b0};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:  reg_rdata = {5'd0, lpb_q, gce_q, en_q};
      RA_GCID: reg_rdata = gcid_q;
      RA_RXD:  reg_rdata = rxd_q;
      RA_TXD:  reg_rdata = txd_q;
      RA_STAT: reg_rdata = stat_w;
      default: begin
        for (int i = 0; i < N_ID; i++) begin
          if (reg_addr == RA_ID0 + REG_AW'(i)) reg_rdata = id_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int IDW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input slv_st_e        st,
  input logic           sda_oe,
  input logic           scl_oe,
  input logic           rxf,
  input logic           stop_flag,
  input logic           busy,
  input logic           en,
  input logic           stop_evt,
  input logic           addr_done,
  input logic           addr_hit,
  input logic           rx_done,
  input logic [IDW-1:0] ids
);
  a_r4_quiet_when_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> (!sda_oe && !scl_oe));

  a_r4_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_oe);

  a_r6_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!sda_oe && !scl_oe));

  a_r7_byte_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rxf);

  a_r9_no_hold_mid_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_TX) && $past(st == ST_TX)) |-> !scl_oe);

  a_r10_stop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && en) |=> stop_flag);

  a_r11_ids_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(ids));
endmodule

bind i2c_multi_slave i2cs_checker #(.IDW(N_ID * 8)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .rxf(rxf_q), .stop_flag(stop_q), .busy(busy_q), .en(en_q),
  .stop_evt(stop_evt), .addr_done(addr_done), .addr_hit(addr_hit),
  .rx_done(rx_done), .ids(id_q)
);

// File: tb/sim_i2c_multi_slave.sv
module sim_i2c_multi_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int WD    = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  logic mon_on = 1'b0, saw_drv = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  i2c_multi_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(negedge clk) if (mon_on && (sda_oe || scl_oe)) saw_drv <= 1'b1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic rwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rrd(a, d);
    chk(req, d, exp);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; hq();
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; hq();
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    hq();
    b = sda_bus;
    scl_m = 1'b0; hq();
  endtask

  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b);
    ack = !b;
  endtask

  task automatic byte_r(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(!give_ack);
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", {7'd0, scl_oe}, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    rchk("R1 status", 4'h8, 8'h40);
    rchk("R1 cfg", 4'h0, 8'h00);
    rchk("R1 id0", 4'h2, 8'h00);
    rchk("R1 rxd", 4'h6, 8'h00);
  endtask

  task automatic t_write_xfer();
    logic ack;
    bus_start();
    byte_w(8'h34, ack);
    chk("R2 ack slot1 bit0 ignored", {7'd0, ack}, 8'h01);
    byte_w(8'h5C, ack);
    chk("R7 data ack", {7'd0, ack}, 8'h01);
    rchk("R3 R7 status slot1 rx full", 4'h8, 8'h62);
    rchk("R7 rx data", 4'h6, 8'h5C);
    rchk("R7 rx full cleared", 4'h8, 8'h42);
    bus_stop();
    rchk("R10 stop flag set", 4'h8, 8'hC2);
    rchk("R10 stop flag cleared", 4'h8, 8'h42);
  endtask

  task automatic t_priority();
    logic ack;
    bus_start();
    byte_w(8'h60, ack);
    chk("R3 ack shared address", {7'd0, ack}, 8'h01);
    bus_stop();
    rchk("R3 lowest slot index 2", 4'h8, 8'hC4);
  endtask

  task automatic t_miss();
    logic ack;
    saw_drv = 1'b0;
    bus_start();
    mon_on = 1'b1;
    byte_w(8'h10, ack);
    chk("R4 no ack on miss", {7'd0, ack}, 8'h00);
    byte_w(8'h00, ack);
    chk("R4 data ignored", {7'd0, ack}, 8'h00);
    mon_on = 1'b0;
    chk("R4 lines never driven", {7'd0, saw_drv}, 8'h00);
    rwr(4'h2, 8'h11);
    rchk("R11 id write dropped while busy", 4'h2, 8'hA0);
    bus_stop();
    rchk("R4 status unchanged, no rx", 4'h8, 8'hC4);
    rwr(4'h2, 8'h22);
    rchk("R11 id write taken when idle", 4'h2, 8'h22);
    rwr(4'h2, 8'hA0);
  endtask

  task automatic t_gencall();
    logic ack;
    logic [7:0] d;
    bus_start();
    byte_w(8'h00, ack);
    chk("R5 gc refused when disabled", {7'd0, ack}, 8'h00);
    bus_stop();
    rrd(4'h8, d);
    rwr(4'h0, 8'h03);
    bus_start();
    byte_w(8'h00, ack);
    chk("R5 gc accepted", {7'd0, ack}, 8'h01);
    rchk("R5 gc status", 4'h8, 8'h48);
    bus_stop();
    rrd(4'h8, d);
    rwr(4'h0, 8'h01);
  endtask

  task automatic t_read_xfer();
    logic ack;
    logic [7:0] d;
    rwr(4'h7, 8'hA5);
    rchk("R8 tx empty cleared", 4'h8, 8'h08);
    bus_start();
    byte_w(8'hA1, ack);
    chk("R2 ack read slot0", {7'd0, ack}, 8'h01);
    byte_r(1'b0, d);
    chk("R8 read byte", d, 8'hA5);
    rchk("R3 R8 status dir read", 4'h8, 8'h50);
    bus_stop();
    rrd(4'h8, d);
  endtask

  task automatic t_stretch();
    logic ack;
    logic [7:0] d;
    bus_start();
    byte_w(8'hA1, ack);
    chk("R9 ack", {7'd0, ack}, 8'h01);
    fork
      byte_r(1'b0, d);
      begin
        repeat (40) @(negedge clk);
        chk("R9 scl held", {6'd0, scl_oe, scl_bus}, 8'h02);
        rwr(4'h7, 8'h3C);
      end
    join
    chk("R9 data after stretch", d, 8'h3C);
    bus_stop();
    rrd(4'h8, d);
  endtask

  task automatic t_loopback();
    rwr(4'h0, 8'h05);
    rwr(4'h7, 8'h77);
    rchk("R12 loopback status", 4'h8, 8'h70);
    rchk("R12 loopback data", 4'h6, 8'h77);
    rwr(4'h0, 8'h01);
  endtask

  task automatic t_disabled();
    logic ack;
    rwr(4'h0, 8'h00);
    saw_drv = 1'b0;
    bus_start();
    mon_on = 1'b1;
    byte_w(8'hA0, ack);
    mon_on = 1'b0;
    chk("R6 no ack when disabled", {7'd0, ack}, 8'h00);
    chk("R6 no drive when disabled", {7'd0, saw_drv}, 8'h00);
    bus_stop();
    rchk("R6 stop not flagged", 4'h8, 8'h50);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rwr(4'h0, 8'h01);
    rwr(4'h2, 8'hA0);
    rwr(4'h3, 8'h35);
    rwr(4'h4, 8'h60);
    rwr(4'h5, 8'h61);
    t_write_xfer();
    t_priority();
    t_miss();
    t_gencall();
    t_read_xfer();
    t_stretch();
    t_loopback();
    t_disabled();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule